// File: doc/BRIEF.md
# ISDN S/T Layer-1 Activation Controller

This block is the terminal-side activation and deactivation sequencer for an ISDN S/T line interface. A microprocessor hands it 4-bit command codes. The line receiver hands it one of four pre-decoded signal classes every cycle. From these two inputs the block chooses which INFO signal the transmitter sends, gates the internal clocks, and holds the D-channel priority class. It reports its state back to the processor as a registered 4-bit indication code.

For line testing, the block can also run in three test modes. Two of them drive a two-wire mark output with pulses of alternating polarity: a continuous stream, or isolated pulses. Both pulse rates come from one tick input through parameterised dividers. The third test mode raises an analog loopback request.

Top module: `l1act_ctrl`

## Requirements
- R1: After reset the block is in the clock-off state. It reports indication CD (1111) with ind_valid high, clk_en low, tx_info INFO 0 (00) and mark 00.
- R2: Command ECK (0000) moves the clock-off state to the deactivated state. That state reports CE (0111), drives clk_en high and sends INFO 0. It stays there while ECK is repeated and INFO 0 (rx class 00) is received.
- R3: Command RST (0001) enters a reset state. In that state ind_valid is low and tx_info is INFO 0, and every received class is ignored. The commands DRC and AR8 are also ignored there and the priority is kept. Only ECK leaves the reset state, and it goes to the deactivated state (CE).
- R4: AR8 (1000) or AR10 (1001) is accepted in the clock-off, deactivated and signal-lost states. Either one moves to the awaiting-signal state, which reports CE and sends INFO 1 (01). AR8 sets the priority to 8 and AR10 sets it to 10. The power-up priority is 8.
- R5: Receiving level without sync (rx class 01) in the awaiting state gives LD (0100) with INFO 0 sent. Any non-INFO-0 class in the clock-off or deactivated state also gives LD, and in the clock-off state it raises clk_en. INFO 0 received in the LD state returns to CE.
- R6: Receiving INFO 2 (rx class 10) in the awaiting, LD, active or signal-lost state gives ARD (1000), with INFO 3 (11) sent.
- R7: Receiving INFO 4 (rx class 11) in the awaiting-path states gives the active state, with INFO 3 sent. The indication is AI8 (1100) when the priority is 8 or 9, and AI10 (1101) when it is 10 or 11.
- R8: Receiving INFO 0 in the ARD or active state gives DRD (0000) and sends INFO 0.
- R9: SCP (0100) enters the test state, which reports TI (1010) and tx_info 10. The mark output (bit1 positive, bit0 negative) is then never idle. It keeps each polarity for CONT_DIV ticks and starts positive.
- R10: SSP (0010) gives TI and tx_info 10. It produces one mark of CONT_DIV ticks per SINGLE_DIV ticks, with the line idle (00) in between, and the polarity alternates from pulse to pulse, starting positive.
- R11: EAL (1010) gives TI, raises loop and sends INFO 3 with mark 00. A non-INFO-0 class during any test mode gives ATI (1011), and INFO 0 returns to TI. ECK ends the test and returns to CE with loop low and mark 00.
- R12: DRC (1111) in any state except reset gives CD, with clk_en low and INFO 0 sent.
- R13: Command codes outside the table (0011, 0101, 0110, 0111, 1011, 1100, 1101, 1110) are ignored: state, indication and priority are unchanged.
- R14: An accepted command takes precedence over the received class in the same cycle. With cmd_valid low, no command is seen. The indication register changes only on a state transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_i | input | 4 | Command code |
| rx_class_i | input | 2 | Received class: 00 INFO 0, 01 level, 10 INFO 2, 11 INFO 4 |
| tick_en_i | input | 1 | Base tick for the pulse dividers |
| ind_o | output | 4 | Registered indication code |
| ind_valid_o | output | 1 | Indication present (low in reset state) |
| tx_info_o | output | 2 | Transmit select: 00 INFO 0, 01 INFO 1, 11 INFO 3, 10 test pulses |
| clk_en_o | output | 1 | Internal clock enable |
| prio_o | output | PRIO_W | D-channel priority level |
| loop_o | output | 1 | Analog loopback request |
| mark_o | output | 2 | Test mark, bit1 positive, bit0 negative |

## Verification
The bench walks the activation path twice. The first pass uses priority 8 and goes through INFO 2 before INFO 4. The second uses priority 10 and goes through level detect before INFO 4. This tells the two active indications apart and separates the ARD, LD and DRD routes. Every undefined command code is swept in the deactivated state, and the reset state is fed received signals and foreign commands, so that silent ignoring shows at the ports. The pulse output is compared cycle by cycle against tick counts worked out arithmetically, once for the continuous pattern and once for the isolated pattern. Only the isolated pattern has idle gaps, and the comparison also shows that the polarity alternates. Command-over-signal precedence is tried by sending an activate request together with a level.

// File: rtl/l1act_pkg.sv
package l1act_pkg;

   localparam int CODE_W = 4;

   localparam logic [CODE_W-1:0] C_ECK  = 4'b0000;
   localparam logic [CODE_W-1:0] C_RST  = 4'b0001;
   localparam logic [CODE_W-1:0] C_SSP  = 4'b0010;
   localparam logic [CODE_W-1:0] C_SCP  = 4'b0100;
   localparam logic [CODE_W-1:0] C_AR8  = 4'b1000;
   localparam logic [CODE_W-1:0] C_AR10 = 4'b1001;
   localparam logic [CODE_W-1:0] C_EAL  = 4'b1010;
   localparam logic [CODE_W-1:0] C_DRC  = 4'b1111;

   localparam logic [CODE_W-1:0] I_DRD  = 4'b0000;
   localparam logic [CODE_W-1:0] I_LD   = 4'b0100;
   localparam logic [CODE_W-1:0] I_CE   = 4'b0111;
   localparam logic [CODE_W-1:0] I_ARD  = 4'b1000;
   localparam logic [CODE_W-1:0] I_TI   = 4'b1010;
   localparam logic [CODE_W-1:0] I_ATI  = 4'b1011;
   localparam logic [CODE_W-1:0] I_AI8  = 4'b1100;
   localparam logic [CODE_W-1:0] I_AI10 = 4'b1101;
   localparam logic [CODE_W-1:0] I_CD   = 4'b1111;

   localparam logic [1:0] RX_INFO0 = 2'b00;
   localparam logic [1:0] RX_LEVEL = 2'b01;
   localparam logic [1:0] RX_INFO2 = 2'b10;
   localparam logic [1:0] RX_INFO4 = 2'b11;

   localparam logic [1:0] TX_INFO0 = 2'b00;
   localparam logic [1:0] TX_INFO1 = 2'b01;
   localparam logic [1:0] TX_PULSE = 2'b10;
   localparam logic [1:0] TX_INFO3 = 2'b11;

   typedef enum logic [3:0] {
      ST_OFF, ST_RST, ST_DEACT, ST_AWAIT, ST_DET,
      ST_SYNC, ST_ACT, ST_LOST, ST_TEST, ST_TLVL
   } l1_state_e;

   typedef enum logic [1:0] {
      TM_NONE, TM_CONT, TM_SINGLE, TM_LOOP
   } tmode_e;

   function automatic logic cmd_known(input logic [CODE_W-1:0] c);
      return (c == C_ECK) || (c == C_RST) || (c == C_SSP) || (c == C_SCP) ||
             (c == C_AR8) || (c == C_AR10) || (c == C_EAL) || (c == C_DRC);
   endfunction

   function automatic logic [CODE_W-1:0] ind_of(input l1_state_e s, input logic high_class);
      case (s)
         ST_OFF:   return I_CD;
         ST_DEACT: return I_CE;
         ST_AWAIT: return I_CE;
         ST_DET:   return I_LD;
         ST_SYNC:  return I_ARD;
         ST_ACT:   return high_class ? I_AI10 : I_AI8;
         ST_LOST:  return I_DRD;
         ST_TEST:  return I_TI;
         ST_TLVL:  return I_ATI;
         default:  return I_DRD;
      endcase
   endfunction

endpackage

// File: rtl/l1act_fsm.sv
module l1act_fsm
   import l1act_pkg::*;
#(
   parameter int PRIO_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid_i,
   input  logic [CODE_W-1:0] cmd_i,
   input  logic [1:0]        rx_class_i,
   output l1_state_e         state_o,
   output tmode_e            tmode_o,
   output logic [PRIO_W-1:0] prio_o,
   output logic [CODE_W-1:0] ind_o,
   output logic              ind_valid_o
);

   localparam logic [PRIO_W-1:0] PRIO_LOW  = PRIO_W'(8);
   localparam logic [PRIO_W-1:0] PRIO_HIGH = PRIO_W'(10);

   if (PRIO_W < 4) begin : g_bad_prio
      $error("l1act_fsm: PRIO_W must hold the value 11");
   end

   l1_state_e         st_q, st_n;
   tmode_e            tm_q, tm_n;
   logic [PRIO_W-1:0] pr_q, pr_n;
   logic [CODE_W-1:0] ind_q;
   logic              ind_vld_q;
   logic              cmd_hit;
   logic              in_test;

   assign in_test = (st_q == ST_TEST) || (st_q == ST_TLVL);

   always_comb begin
      st_n    = st_q;
      tm_n    = tm_q;
      pr_n    = pr_q;
      cmd_hit = 1'b0;
      if (st_q == ST_RST) begin
         if (cmd_valid_i && cmd_i == C_ECK) st_n = ST_DEACT;
      end else begin
         if (cmd_valid_i) begin
            case (cmd_i)
               C_RST: begin
                  st_n = ST_RST; tm_n = TM_NONE; cmd_hit = 1'b1;
               end
               C_DRC: begin
                  st_n = ST_OFF; tm_n = TM_NONE; cmd_hit = 1'b1;
               end
               C_ECK: begin
                  if (in_test || st_q == ST_OFF) begin
                     st_n = ST_DEACT; tm_n = TM_NONE; cmd_hit = 1'b1;
                  end
               end
               C_AR8, C_AR10: begin
                  if (st_q == ST_OFF || st_q == ST_DEACT || st_q == ST_LOST) begin
                     st_n    = ST_AWAIT;
                     pr_n    = (cmd_i == C_AR10) ? PRIO_HIGH : PRIO_LOW;
                     cmd_hit = 1'b1;
                  end
               end
               C_SCP, C_SSP, C_EAL: begin
                  if (in_test || st_q == ST_OFF || st_q == ST_DEACT) begin
                     st_n    = (st_q == ST_TLVL) ? ST_TLVL : ST_TEST;
                     tm_n    = (cmd_i == C_SCP) ? TM_CONT :
                               (cmd_i == C_SSP) ? TM_SINGLE : TM_LOOP;
                     cmd_hit = 1'b1;
                  end
               end
               default: cmd_hit = 1'b0;
            endcase
         end
         if (!cmd_hit) begin
            case (st_q)
               ST_OFF, ST_DEACT: if (rx_class_i != RX_INFO0) st_n = ST_DET;
               ST_AWAIT: begin
                  if (rx_class_i == RX_LEVEL)      st_n = ST_DET;
                  else if (rx_class_i == RX_INFO2) st_n = ST_SYNC;
                  else if (rx_class_i == RX_INFO4) st_n = ST_ACT;
               end
               ST_DET: begin
                  if (rx_class_i == RX_INFO0)      st_n = ST_DEACT;
                  else if (rx_class_i == RX_INFO2) st_n = ST_SYNC;
                  else if (rx_class_i == RX_INFO4) st_n = ST_ACT;
               end
               ST_SYNC: begin
                  if (rx_class_i == RX_INFO0)      st_n = ST_LOST;
                  else if (rx_class_i == RX_INFO4) st_n = ST_ACT;
               end
               ST_ACT: begin
                  if (rx_class_i == RX_INFO0)      st_n = ST_LOST;
                  else if (rx_class_i == RX_INFO2) st_n = ST_SYNC;
               end
               ST_LOST: begin
                  if (rx_class_i == RX_LEVEL)      st_n = ST_DET;
                  else if (rx_class_i == RX_INFO2) st_n = ST_SYNC;
                  else if (rx_class_i == RX_INFO4) st_n = ST_ACT;
               end
               ST_TEST: if (rx_class_i != RX_INFO0) st_n = ST_TLVL;
               ST_TLVL: if (rx_class_i == RX_INFO0) st_n = ST_TEST;
               default: st_n = st_q;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_OFF;
         tm_q      <= TM_NONE;
         pr_q      <= PRIO_LOW;
         ind_q     <= I_CD;
         ind_vld_q <= 1'b1;
      end else begin
         st_q <= st_n;
         tm_q <= tm_n;
         pr_q <= pr_n;
         if (st_n != st_q) begin
            ind_q     <= ind_of(st_n, pr_n >= PRIO_HIGH);
            ind_vld_q <= (st_n != ST_RST);
         end
      end
   end

   assign state_o     = st_q;
   assign tmode_o     = tm_q;
   assign prio_o      = pr_q;
   assign ind_o       = ind_q;
   assign ind_valid_o = ind_vld_q;

   // R3: only ECK leaves the reset state
   p_rst_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RST && !(cmd_valid_i && cmd_i == C_ECK)) |=> (st_q == ST_RST));

   // R3: no indication while in reset state
   p_rst_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RST) |-> !ind_vld_q);

   // R13: undefined codes in a holding state change nothing
   p_unknown_cmd_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && !cmd_known(cmd_i) && rx_class_i == RX_INFO0 &&
       (st_q == ST_OFF || st_q == ST_DEACT || st_q == ST_AWAIT || st_q == ST_TEST))
      |=> ($stable(st_q) && $stable(pr_q)));

   // R14: indication moves only with the state
   p_ind_on_move_r14: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ind_q) |-> !$stable(st_q));

endmodule

// File: rtl/l1act_pulse_gen.sv
module l1act_pulse_gen
   import l1act_pkg::*;
#(
   parameter int CONT_DIV   = 2,
   parameter int SINGLE_DIV = 96,
   parameter bit REG_OUT    = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en_i,
   input  tmode_e     mode_i,
   output logic [1:0] mark_o
);

   localparam int CNT_W = $clog2(SINGLE_DIV + 1);
   localparam logic [CNT_W-1:0] CONT_LAST = CNT_W'(CONT_DIV - 1);
   localparam logic [CNT_W-1:0] SGL_LAST  = CNT_W'(SINGLE_DIV - 1);
   localparam logic [CNT_W-1:0] MARK_LEN  = CNT_W'(CONT_DIV);

   if (CONT_DIV < 1) begin : g_bad_cont
      $error("l1act_pulse_gen: CONT_DIV must be at least 1");
   end
   if (SINGLE_DIV <= CONT_DIV) begin : g_bad_single
      $error("l1act_pulse_gen: SINGLE_DIV must exceed CONT_DIV");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             pol_q;
   tmode_e           mode_q;
   logic             pulsing;
   logic             active;
   logic [CNT_W-1:0] last;
   logic [1:0]       mark_c;

   assign pulsing = (mode_i == TM_CONT) || (mode_i == TM_SINGLE);
   assign last    = (mode_i == TM_CONT) ? CONT_LAST : SGL_LAST;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pol_q  <= 1'b0;
         mode_q <= TM_NONE;
      end else begin
         mode_q <= mode_i;
         if (!pulsing || mode_i != mode_q) begin
            cnt_q <= '0;
            pol_q <= 1'b0;
         end else if (tick_en_i) begin
            if (cnt_q == last) begin
               cnt_q <= '0;
               pol_q <= ~pol_q;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   always_comb begin
      case (mode_i)
         TM_CONT:   active = 1'b1;
         TM_SINGLE: active = (cnt_q < MARK_LEN);
         default:   active = 1'b0;
      endcase
      mark_c = active ? (pol_q ? 2'b01 : 2'b10) : 2'b00;
   end

   if (REG_OUT) begin : g_reg_out
      logic [1:0] mark_q;
      always_ff @(posedge clk) begin
         if (!rst_n) mark_q <= 2'b00;
         else        mark_q <= mark_c;
      end
      assign mark_o = mark_q;
   end else begin : g_comb_out
      assign mark_o = mark_c;
   end

   // R9: never both polarities at once
   p_mark_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mark_o));

   // R9: continuous mode keeps the line marked
   p_cont_marked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == TM_CONT && $past(mode_i) == TM_CONT) |-> (mark_o != 2'b00));

   // R11: no marks outside the pulse modes
   p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != TM_CONT && mode_i != TM_SINGLE && !REG_OUT) |-> (mark_o == 2'b00));

endmodule

// File: rtl/l1act_txmap.sv
module l1act_txmap
   import l1act_pkg::*;
(
   input  l1_state_e  state_i,
   input  tmode_e     tmode_i,
   output logic [1:0] tx_info_o,
   output logic       clk_en_o,
   output logic       loop_o
);

   logic testing;
   assign testing = (state_i == ST_TEST) || (state_i == ST_TLVL);

   always_comb begin
      case (state_i)
         ST_AWAIT:         tx_info_o = TX_INFO1;
         ST_SYNC, ST_ACT:  tx_info_o = TX_INFO3;
         ST_TEST, ST_TLVL: tx_info_o = (tmode_i == TM_LOOP) ? TX_INFO3 : TX_PULSE;
         default:          tx_info_o = TX_INFO0;
      endcase
   end

   assign clk_en_o = (state_i != ST_OFF);
   assign loop_o   = testing && (tmode_i == TM_LOOP);

endmodule

// File: rtl/l1act_ctrl.sv
module l1act_ctrl
   import l1act_pkg::*;
#(
   parameter int PRIO_W     = 4,
   parameter int CONT_DIV   = 2,
   parameter int SINGLE_DIV = 96,
   parameter bit REG_OUT    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid_i,
   input  logic [3:0]        cmd_i,
   input  logic [1:0]        rx_class_i,
   input  logic              tick_en_i,
   output logic [3:0]        ind_o,
   output logic              ind_valid_o,
   output logic [1:0]        tx_info_o,
   output logic              clk_en_o,
   output logic [PRIO_W-1:0] prio_o,
   output logic              loop_o,
   output logic [1:0]        mark_o
);

   l1_state_e state;
   tmode_e    tmode;

   l1act_fsm #(.PRIO_W(PRIO_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid_i (cmd_valid_i),
      .cmd_i       (cmd_i),
      .rx_class_i  (rx_class_i),
      .state_o     (state),
      .tmode_o     (tmode),
      .prio_o      (prio_o),
      .ind_o       (ind_o),
      .ind_valid_o (ind_valid_o)
   );

   l1act_txmap u_txmap (
      .state_i   (state),
      .tmode_i   (tmode),
      .tx_info_o (tx_info_o),
      .clk_en_o  (clk_en_o),
      .loop_o    (loop_o)
   );

   l1act_pulse_gen #(
      .CONT_DIV   (CONT_DIV),
      .SINGLE_DIV (SINGLE_DIV),
      .REG_OUT    (REG_OUT)
   ) u_pulse (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en_i (tick_en_i),
      .mode_i    (tmode),
      .mark_o    (mark_o)
   );

   // R12: clock-off indication means clocks gated
   p_off_noclk_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_valid_o && ind_o == I_CD) |-> !clk_en_o);

   // R3: silent reset state sends INFO 0
   p_rst_info0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ind_valid_o |-> (tx_info_o == TX_INFO0));

   // R6: ARD pairs with INFO 3 on the line
   p_ard_info3_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_valid_o && ind_o == I_ARD) |-> (tx_info_o == TX_INFO3));

endmodule

// File: tb/l1act_ctrl_bench.sv
module l1act_ctrl_bench;

   localparam int CD = 2;
   localparam int SD = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [3:0] cmd = 4'b0000;
   logic [1:0] rx = 2'b00;
   logic       tick = 1'b1;
   logic [3:0] ind;
   logic       ind_valid;
   logic [1:0] tx_info;
   logic       clk_en;
   logic [3:0] prio;
   logic       loop;
   logic [1:0] mark;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   l1act_ctrl #(.PRIO_W(4), .CONT_DIV(CD), .SINGLE_DIV(SD), .REG_OUT(1'b0)) u_l1act_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
      .rx_class_i(rx), .tick_en_i(tick), .ind_o(ind), .ind_valid_o(ind_valid),
      .tx_info_o(tx_info), .clk_en_o(clk_en), .prio_o(prio), .loop_o(loop),
      .mark_o(mark)
   );

   task automatic apply(input logic v, input logic [3:0] c, input logic [1:0] r);
      cmd_valid = v; cmd = c; rx = r;
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_ind(input string req, input int vld, input int code, input int txe);
      chk(req, "ind_valid", int'(ind_valid), vld);
      if (vld != 0) chk(req, "ind", int'(ind), code);
      chk(req, "tx_info", int'(tx_info), txe);
   endtask

   function automatic int exp_mark(input bit single, input int n);
      int pol;
      if (!single) begin
         pol = (n / CD) % 2;
         return (pol != 0) ? 1 : 2;
      end
      if ((n % SD) >= CD) return 0;
      pol = (n / SD) % 2;
      return (pol != 0) ? 1 : 2;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk_ind("R1", 1, 4'b1111, 0);
      chk("R1", "clk_en", int'(clk_en), 0);
      chk("R1", "mark", int'(mark), 0);
      chk("R1", "prio", int'(prio), 8);
      apply(0, 4'b0000, 2'b00);
      apply(1, 4'b0011, 2'b00);
      chk_ind("R13", 1, 4'b1111, 0);   // R13 undefined code in clock-off
      chk("R13", "clk_en", int'(clk_en), 0);

      // R2 enable clocks
      apply(1, 4'b0000, 2'b00);
      chk_ind("R2", 1, 4'b0111, 0);
      chk("R2", "clk_en", int'(clk_en), 1);
      for (int i = 0; i < 3; i++) begin
         apply(1, 4'b0000, 2'b00);
         chk_ind("R2", 1, 4'b0111, 0);
      end

      // R13 sweep of undefined codes
      for (int c = 0; c < 16; c++) begin
         if (c == 0 || c == 1 || c == 2 || c == 4 || c == 8 || c == 9 || c == 10 || c == 15)
            continue;
         apply(1, 4'(c), 2'b00);
         apply(0, 4'b0000, 2'b00);
         chk_ind("R13", 1, 4'b0111, 0);
         chk("R13", "prio", int'(prio), 8);
      end

      // R4 activate at priority 8, R6, R7, R8
      apply(1, 4'b1000, 2'b00);
      chk_ind("R4", 1, 4'b0111, 1);
      chk("R4", "prio", int'(prio), 8);
      apply(0, 4'b0000, 2'b10);
      chk_ind("R6", 1, 4'b1000, 3);
      apply(0, 4'b0000, 2'b11);
      chk_ind("R7", 1, 4'b1100, 3);
      apply(0, 4'b0000, 2'b00);
      chk_ind("R8", 1, 4'b0000, 0);

      // R4 priority 10, R5, R7 AI10
      apply(1, 4'b1001, 2'b00);
      chk_ind("R4", 1, 4'b0111, 1);
      chk("R4", "prio", int'(prio), 10);
      apply(0, 4'b0000, 2'b01);
      chk_ind("R5", 1, 4'b0100, 0);
      apply(0, 4'b0000, 2'b11);
      chk_ind("R7", 1, 4'b1101, 3);
      apply(0, 4'b0000, 2'b10);
      chk_ind("R6", 1, 4'b1000, 3);
      apply(0, 4'b0000, 2'b00);
      chk_ind("R8", 1, 4'b0000, 0);

      // R12 deactivate, R5 wake from clock-off
      apply(1, 4'b1111, 2'b00);
      chk_ind("R12", 1, 4'b1111, 0);
      chk("R12", "clk_en", int'(clk_en), 0);
      apply(0, 4'b0000, 2'b01);
      chk_ind("R5", 1, 4'b0100, 0);
      chk("R5", "clk_en", int'(clk_en), 1);
      apply(0, 4'b0000, 2'b00);
      chk_ind("R5", 1, 4'b0111, 0);

      // R3 reset state
      apply(1, 4'b0001, 2'b00);
      chk_ind("R3", 0, 0, 0);
      apply(0, 4'b0000, 2'b10);
      chk_ind("R3", 0, 0, 0);
      apply(1, 4'b1111, 2'b11);
      chk_ind("R3", 0, 0, 0);
      chk("R3", "clk_en", int'(clk_en), 1);
      apply(1, 4'b1000, 2'b01);
      chk_ind("R3", 0, 0, 0);
      chk("R3", "prio", int'(prio), 10);
      apply(1, 4'b0000, 2'b00);
      chk_ind("R3", 1, 4'b0111, 0);

      // R14 command beats received level
      apply(1, 4'b1000, 2'b01);
      chk_ind("R14", 1, 4'b0111, 1);
      chk("R14", "prio", int'(prio), 8);
      apply(0, 4'b1111, 2'b00);
      chk_ind("R14", 1, 4'b0111, 1);   // cmd_valid low: DRC not seen
      apply(1, 4'b1111, 2'b00);
      apply(1, 4'b0000, 2'b00);
      chk_ind("R12", 1, 4'b0111, 0);

      // R9 continuous pulses
      apply(1, 4'b0100, 2'b00);
      chk_ind("R9", 1, 4'b1010, 2);
      chk("R9", "mark", int'(mark), exp_mark(1'b0, 0));
      for (int k = 1; k <= 24; k++) begin
         apply(0, 4'b0000, 2'b00);
         chk("R9", "mark", int'(mark), exp_mark(1'b0, k - 1));
      end

      // R10 single pulses
      apply(1, 4'b0010, 2'b00);
      chk_ind("R10", 1, 4'b1010, 2);
      for (int k = 1; k <= 40; k++) begin
         apply(0, 4'b0000, 2'b00);
         chk("R10", "mark", int'(mark), exp_mark(1'b1, k - 1));
      end

      // R11 awake test and loopback
      apply(0, 4'b0000, 2'b01);
      chk_ind("R11", 1, 4'b1011, 2);
      apply(0, 4'b0000, 2'b00);
      chk_ind("R11", 1, 4'b1010, 2);
      apply(1, 4'b1010, 2'b00);
      chk_ind("R11", 1, 4'b1010, 3);
      chk("R11", "loop", int'(loop), 1);
      chk("R11", "mark", int'(mark), 0);
      apply(0, 4'b0000, 2'b11);
      chk_ind("R11", 1, 4'b1011, 3);
      apply(1, 4'b0000, 2'b00);
      chk_ind("R11", 1, 4'b0111, 0);
      chk("R11", "loop", int'(loop), 0);
      chk("R11", "mark", int'(mark), 0);

      apply(0, 4'b0000, 2'b00);
      finish_run();
   end

endmodule